// File: doc/BRIEF.md
# Board Control Register Block

A small register slave that sits on a simple 32-bit register bus with a valid strobe, a write enable, a byte offset into a 64 KiB window, write data and read data. Software reads two fixed identification words from it: a build-date code and the processor clock rate in hertz. It also drives a bank of LEDs from a read/write register and reads back a bank of DIP switches.

The switch pins are not assumed to be synchronous to the bus clock. They pass through a two-flop synchronizer before software can read them. A dedicated reset offset accepts one magic value. Writing that value makes the block raise a one-cycle system reset request. Writing any other value there does nothing. Unmapped offsets read as zero and ignore writes.

Read data is registered and appears in the cycle after the read strobe. In every other cycle the read data output is held at zero, so several such slaves can share a bus by an OR of their read data.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at byte offset 0x0 returns the build code 0x09272011.
- R2: A read at byte offset 0x4 returns the processor clock rate, 10,000,000 (0x00989680).
- R3: A write at offset 0x8 loads bits [LED_W-1:0] of the write data into the LED register. `led_out` shows the new value in the cycle after the write. A read at 0x8 returns the LED register, zero-extended. An LED bit at 1 means the LED is lit.
- R4: A read at offset 0xC returns the synchronized switch state, zero-extended, with 1 meaning the switch is on. A pin change reaches the readback two clocks later: a read sampled on the first edge after the change returns the old value. Writes to 0xC have no effect.
- R5: A write of exactly 0x0000DEAD at offset 0x10 raises `reset_req` for exactly one cycle, starting in the cycle after the write. A write of any other value at 0x10 leaves `reset_req` low.
- R6: While `rst_n` is low, the LED register, `bus_rdata` and `reset_req` are all zero. This holds for a reset applied in the middle of operation as well as at power-up.
- R7: A read at any offset other than 0x0, 0x4, 0x8 or 0xC returns zero. A write at any offset other than 0x8 or 0x10 changes neither the LED register nor `reset_req`.
- R8: Read data is valid in exactly the one cycle after a read strobe (valid high, write enable low). In every cycle that does not follow a read strobe it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously upstream |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte offset inside the 64 KiB window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data, zero when idle |
| sw_in | input | SW_W (8) | Asynchronous DIP switch pins |
| led_out | output | LED_W (8) | LED drive, 1 = lit |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that every access is a single-cycle strobe, and that `bus_we` and `bus_addr` are meaningful only while `bus_valid` is high. They also assume that `rst_n` rises away from the clock edge. The bench drives each access for exactly one cycle from the falling edge, and it lowers `bus_valid` between accesses except where it deliberately holds a read to probe switch latency. The switch pins change only on the falling edge, so the synchronizer latency the bench expects is a whole number of clocks.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  // Byte offsets inside the decode window; software depends on these.
  localparam int unsigned OFF_BUILD = 32'h0000_0000;
  localparam int unsigned OFF_CLKHZ = 32'h0000_0004;
  localparam int unsigned OFF_LED   = 32'h0000_0008;
  localparam int unsigned OFF_SW    = 32'h0000_000C;
  localparam int unsigned OFF_RST   = 32'h0000_0010;
  // Value that must land on OFF_RST to request a system reset.
  localparam logic [31:0] RST_MAGIC = 32'h0000_DEAD;
endpackage

// File: rtl/bctl_sync.sv
module bctl_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = d_async;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q_sync = stab_q;
endmodule

// File: rtl/bctl_pulse.sv
module bctl_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;

  // R6: request is low while reset is held
  always_comb begin
    if (!rst_n) a_req_in_reset_r6: assert (pulse_q == 1'b0);
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LED_W      = 8,
  parameter int unsigned SW_W       = 8,
  parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
  parameter int unsigned CLK_HZ     = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [LED_W-1:0]  led_out,
  output logic              reset_req
);
  localparam logic [ADDR_W-1:0] A_BUILD = ADDR_W'(OFF_BUILD);
  localparam logic [ADDR_W-1:0] A_CLKHZ = ADDR_W'(OFF_CLKHZ);
  localparam logic [ADDR_W-1:0] A_LED   = ADDR_W'(OFF_LED);
  localparam logic [ADDR_W-1:0] A_SW    = ADDR_W'(OFF_SW);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(OFF_RST);
  localparam logic [DATA_W-1:0] BUILD_W = DATA_W'(BUILD_CODE);
  localparam logic [DATA_W-1:0] CLK_W   = DATA_W'(CLK_HZ);
  localparam logic [DATA_W-1:0] MAGIC_W = DATA_W'(RST_MAGIC);

  logic rd_en, wr_en;
  assign rd_en = bus_valid & ~bus_we;
  assign wr_en = bus_valid & bus_we;

  // Switch synchronizer
  logic [SW_W-1:0] sw_sync;
  bctl_sync #(.W(SW_W)) u_sw_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sw_in),
    .q_sync  (sw_sync)
  );

  // LED register
  logic [LED_W-1:0] led_q, led_d;
  logic             led_en;

  always_comb begin
    led_en = wr_en && (bus_addr == A_LED);
    led_d  = bus_wdata[LED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= '0;
    else if (led_en) led_q <= led_d;
  end

  assign led_out = led_q;

  // Reset request
  logic rst_fire;
  always_comb rst_fire = wr_en && (bus_addr == A_RST) && (bus_wdata == MAGIC_W);

  bctl_pulse u_rst_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (rst_fire),
    .pulse (reset_req)
  );

  // Read path
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      case (bus_addr)
        A_BUILD: rdata_d = BUILD_W;
        A_CLKHZ: rdata_d = CLK_W;
        A_LED:   rdata_d = DATA_W'(led_q);
        A_SW:    rdata_d = DATA_W'(sw_sync);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // Assertions
  // R8: no read strobe in the previous cycle means idle read data
  p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && !bus_we) |-> (bus_rdata == '0));

  // R3, R7: the LEDs move only after a write at the LED offset
  p_led_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && bus_we && (bus_addr == A_LED)) |-> $stable(led_out));

  // R3: an LED write lands on the pins one cycle later
  p_led_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && (bus_addr == A_LED)) |=> (led_out == $past(bus_wdata[LED_W-1:0])));

  // R5: request is a single-cycle pulse
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R5: request only follows a magic write at the reset offset
  p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(bus_valid && bus_we && (bus_addr == A_RST) && (bus_wdata == MAGIC_W)));

  // R1: build-code read returns the constant
  p_build_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && (bus_addr == A_BUILD)) |=> (bus_rdata == BUILD_W));
endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  sw_in, led_out;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sw_in(sw_in), .led_out(led_out), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    idle();
    d = bus_rdata;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); sw_in = '0;
    repeat (3) @(negedge clk);
    check("R6 led at reset", {24'h0, led_out}, 32'h0);
    check("R6 rdata at reset", bus_rdata, 32'h0);
    check("R6 req at reset", {31'h0, reset_req}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_consts();
    logic [31:0] d;
    bus_read(16'h0000, d); check("R1 build code", d, 32'h0927_2011);
    bus_read(16'h0004, d); check("R2 clock rate", d, 32'd10_000_000);
  endtask

  task automatic t_led();
    logic [31:0] d;
    bus_write(16'h0008, 32'hFFFF_FF5A);
    check("R3 led pins", {24'h0, led_out}, 32'h5A);
    bus_read(16'h0008, d); check("R3 led readback", d, 32'h0000_005A);
    bus_write(16'h0008, 32'h0000_00C3);
    bus_read(16'h0008, d); check("R3 led rewrite", d, 32'h0000_00C3);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    @(negedge clk); sw_in = 8'hA5;
    repeat (3) @(negedge clk);
    bus_read(16'h000C, d); check("R4 switch settled", d, 32'h0000_00A5);
    // change pins and read on the very next edge: old value expected
    @(negedge clk);
    sw_in = 8'h3C; bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 16'h000C;
    @(negedge clk);
    check("R4 switch lag edge1", bus_rdata, 32'h0000_00A5);
    @(negedge clk);
    check("R4 switch lag edge2", bus_rdata, 32'h0000_00A5);
    @(negedge clk);
    idle();
    check("R4 switch new edge3", bus_rdata, 32'h0000_003C);
    bus_write(16'h000C, 32'h0000_00FF);
    bus_read(16'h000C, d); check("R4 switch write ignored", d, 32'h0000_003C);
    check("R4 led untouched", {24'h0, led_out}, 32'h0000_00C3);
  endtask

  task automatic t_reset_req();
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 16'h0010; bus_wdata = 32'h0000_DEAD;
    @(negedge clk);
    idle();
    check("R5 req pulse high", {31'h0, reset_req}, 32'h1);
    @(negedge clk);
    check("R5 req pulse one cycle", {31'h0, reset_req}, 32'h0);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 16'h0010; bus_wdata = 32'h0001_DEAD;
    @(negedge clk);
    idle();
    check("R5 wrong value no req", {31'h0, reset_req}, 32'h0);
    @(negedge clk);
    check("R5 wrong value still none", {31'h0, reset_req}, 32'h0);
    check("R5 led kept", {24'h0, led_out}, 32'h0000_00C3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(16'h0014, 32'h0000_0011);
    check("R7 unmapped write led", {24'h0, led_out}, 32'h0000_00C3);
    check("R7 unmapped write req", {31'h0, reset_req}, 32'h0);
    bus_read(16'h0010, d); check("R7 reset offset reads zero", d, 32'h0);
    bus_read(16'h0009, d); check("R7 misaligned reads zero", d, 32'h0);
    bus_read(16'hFFFC, d); check("R7 top of window zero", d, 32'h0);
    bus_write(16'h1008, 32'h0000_0077);
    bus_read(16'h0008, d); check("R7 alias write ignored", d, 32'h0000_00C3);
  endtask

  task automatic t_read_timing();
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 16'h0000;
    @(negedge clk);
    idle();
    check("R8 data one cycle after", bus_rdata, 32'h0927_2011);
    @(negedge clk);
    check("R8 data zero after", bus_rdata, 32'h0);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 16'h0004; bus_wdata = 32'h1234_5678;
    @(negedge clk);
    idle();
    check("R8 write gives no data", bus_rdata, 32'h0);
  endtask

  task automatic t_midrun_reset();
    bus_write(16'h0008, 32'h0000_00F0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R6 async led clear", {24'h0, led_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R6 led zero after reset", {24'h0, led_out}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_consts();
    t_led();
    t_switch();
    t_reset_req();
    t_unmapped();
    t_read_timing();
    t_midrun_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule